// File: doc/BRIEF.md
# Glitch-Free Programmable Reference Clock Divider

This block derives a slower clock from a fast reference clock. A 4-bit divide value N sets the output period to N+1 reference cycles. N is held in an 8-bit configuration byte that software writes and reads back over a simple register port. The same byte also holds two control bits that neighbouring logic uses:

- an arm bit that must be set before any DMA transfer, driven straight to an output;
- a bit that narrows the interrupt output to start-of-frame events only.

A new divide value never cuts a running period short. The value is first written into the byte, which acts as a shadow copy. The divider takes it on only at the rising edge that starts the next period, and every period opens with its high phase. With N equal to zero the reference clock itself is routed to the output. The choice between the reference clock and the divided clock is only switched at a period boundary.

Two resets are used. A power-on reset restores the whole byte. A bus reset leaves the byte and the divider running as they are, and only drops the registered interrupt output.

Top module: `refclk_div_top`

## Requirements
- R1: With N from 1 to 11, each output period lasts N+1 reference cycles. The high phase is ceil((N+1)/2) cycles and the low phase is floor((N+1)/2) cycles, so an odd ratio has the longer high phase. Each period begins with its high phase.
- R2: After a power-on reset the configuration byte reads 0x0B (N = 11, both control bits 0). The divider runs at 12 reference cycles per period, `dma_arm` is 0 and `irq` is 0.
- R3: Layout of the configuration byte on `cfg_rdata`:
  - bits [3:0] hold the programmed N;
  - bit 6 is the arm bit, also driven on `dma_arm`;
  - bit 7 is the SOF-only interrupt bit;
  - bits [5:4] always read 0, and the values written to them are ignored.
- R4: A written N above 11 is stored and used as 11.
- R5: A write landing during a period leaves that period's high and low lengths at the old value. The new N governs the periods that follow. The read-back shows the new value on the cycle after the write.
- R6: When N is 0 the output follows the reference clock. Entering or leaving this mode happens only at a period boundary, and the divided clock after leaving it has the new ratio.
- R7: While `bus_rst` is high, the configuration byte and the divider are unchanged and `irq` is forced to 0 on the next cycle.
- R8: With the SOF-only bit set, `irq` on each cycle equals the value `sof_tick` had on the previous cycle. `evt_irq` and `alt_sof_mode` have no effect.
- R9: With the SOF-only bit clear, `irq` on each cycle equals `evt_irq OR (alt_sof_mode AND sof_tick)` from the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock, also the clock of every register |
| por | input | 1 | Synchronous active-high power-on reset |
| bus_rst | input | 1 | Synchronous active-high bus reset (configuration kept) |
| wr_en | input | 1 | Write strobe for the configuration byte |
| wr_data | input | 8 | Value written to the configuration byte |
| cfg_rdata | output | 8 | Current configuration byte |
| evt_irq | input | 1 | OR of the ordinary interrupt sources |
| alt_sof_mode | input | 1 | Mode bit from elsewhere that adds SOF events to the ordinary interrupt |
| sof_tick | input | 1 | One-cycle pulse for each start-of-frame |
| clk_out | output | 1 | Divided or bypassed output clock |
| dma_arm | output | 1 | Arm bit of the configuration byte |
| irq | output | 1 | Registered interrupt output |

## Verification
A counter that steps past its limit, or a shadow value loaded too early, appears at `clk_out` within one output period, at most 12 reference cycles. It shows up as a high or low phase with the wrong length, which the bench measures directly by counting samples. A wrong bypass select appears at once as an output that fails to follow the reference clock's low half-cycle. A corrupted configuration byte is visible the cycle after it happens on `cfg_rdata` and `dma_arm`. A wrong interrupt source choice surfaces one cycle after the input pattern that exposes it.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int unsigned DIV_W = 4;
    localparam int unsigned CFG_W = 8;

    typedef struct packed {
        logic             sof_only;
        logic             dma_arm;
        logic [1:0]       rsvd;
        logic [DIV_W-1:0] div_n;
    } cfg_byte_t;

    typedef enum logic {
        MODE_DIVIDE = 1'b0,
        MODE_BYPASS = 1'b1
    } out_mode_e;

    function automatic logic [DIV_W-1:0] clamp_div(input logic [DIV_W-1:0] v,
                                                   input logic [DIV_W-1:0] lim);
        return (v > lim) ? lim : v;
    endfunction

    // cycles of high phase for a period of n+1: ceil((n+1)/2)
    function automatic logic [DIV_W:0] high_len(input logic [DIV_W-1:0] n);
        return ({1'b0, n} + (DIV_W+1)'(2)) >> 1;
    endfunction

endpackage

// File: rtl/cfg_store.sv
module cfg_store
    import clkdiv_pkg::*;
#(
    parameter int unsigned N_MAX = 11,
    parameter int unsigned N_RST = 11
) (
    input  logic             clk,
    input  logic             por,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output cfg_byte_t        cfg_q
);
    localparam logic [DIV_W-1:0] N_MAX_V = DIV_W'(N_MAX);
    localparam logic [DIV_W-1:0] N_RST_V = DIV_W'(N_RST);

    logic unused_rsvd_bits;
    assign unused_rsvd_bits = ^wr_data[5:4];

    cfg_byte_t cfg_d;
    always_comb begin
        cfg_d.sof_only = wr_data[7];
        cfg_d.dma_arm  = wr_data[6];
        cfg_d.rsvd     = 2'b00;
        cfg_d.div_n    = clamp_div(wr_data[DIV_W-1:0], N_MAX_V);
    end

    always_ff @(posedge clk) begin
        if (por) begin
            cfg_q.sof_only <= 1'b0;
            cfg_q.dma_arm  <= 1'b0;
            cfg_q.rsvd     <= 2'b00;
            cfg_q.div_n    <= N_RST_V;
        end else if (wr_en) begin
            cfg_q <= cfg_d;
        end
    end

    p_clamped_div_r4: assert property (@(posedge clk) disable iff (por)
        cfg_q.div_n <= N_MAX_V);

    p_rsvd_zero_r3: assert property (@(posedge clk) disable iff (por)
        cfg_q.rsvd == 2'b00);

endmodule

// File: rtl/div_core.sv
module div_core
    import clkdiv_pkg::*;
#(
    parameter int unsigned N_RST = 11
) (
    input  logic             clk,
    input  logic             por,
    input  logic [DIV_W-1:0] n_shadow,
    output logic             div_q,
    output out_mode_e        mode
);
    localparam logic [DIV_W-1:0] N_RST_V = DIV_W'(N_RST);

    logic [DIV_W-1:0] cnt, cur_n;
    logic [DIV_W-1:0] cnt_nx, n_eff;
    logic             wrap;

    always_comb begin
        wrap   = (cnt == cur_n);
        n_eff  = wrap ? n_shadow : cur_n;
        cnt_nx = wrap ? '0 : cnt + DIV_W'(1);
    end

    always_ff @(posedge clk) begin
        if (por) begin
            cnt   <= N_RST_V;
            cur_n <= N_RST_V;
            div_q <= 1'b0;
        end else begin
            cnt   <= cnt_nx;
            cur_n <= n_eff;
            div_q <= ({1'b0, cnt_nx} < high_len(n_eff));
        end
    end

    assign mode = (cur_n == '0) ? MODE_BYPASS : MODE_DIVIDE;

    p_cnt_in_range_r1: assert property (@(posedge clk) disable iff (por)
        cnt <= cur_n);

    p_period_opens_high_r1: assert property (@(posedge clk) disable iff (por)
        (cnt == '0) |-> div_q);

    p_load_at_boundary_r5: assert property (@(posedge clk) disable iff (por)
        !$stable(cur_n) |-> ($past(cnt) == $past(cur_n)));

    p_mode_switch_boundary_r6: assert property (@(posedge clk) disable iff (por)
        !$stable(mode) |-> (cnt == '0));

endmodule

// File: rtl/out_mux.sv
module out_mux
    import clkdiv_pkg::*;
(
    input  logic      ref_clk,
    input  logic      div_q,
    input  out_mode_e mode,
    output logic      clk_out
);
    // mode only changes on the edge that opens a period, when both legs are high
    assign clk_out = (mode == MODE_BYPASS) ? ref_clk : div_q;
endmodule

// File: rtl/irq_sel.sv
module irq_sel (
    input  logic clk,
    input  logic por,
    input  logic bus_rst,
    input  logic sof_only,
    input  logic evt_irq,
    input  logic alt_sof_mode,
    input  logic sof_tick,
    output logic irq_q
);
    always_ff @(posedge clk) begin
        if (por || bus_rst)
            irq_q <= 1'b0;
        else if (sof_only)
            irq_q <= sof_tick;
        else
            irq_q <= evt_irq | (alt_sof_mode & sof_tick);
    end

    p_sof_only_ignores_events_r8: assert property (@(posedge clk) disable iff (por)
        (sof_only && !bus_rst && !sof_tick) |=> !irq_q);

    p_bus_rst_drops_irq_r7: assert property (@(posedge clk) disable iff (por)
        bus_rst |=> !irq_q);

endmodule

// File: rtl/refclk_div_top.sv
module refclk_div_top
    import clkdiv_pkg::*;
#(
    parameter int unsigned N_MAX = 11,
    parameter int unsigned N_RST = 11
) (
    input  logic       ref_clk,
    input  logic       por,
    input  logic       bus_rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] cfg_rdata,
    input  logic       evt_irq,
    input  logic       alt_sof_mode,
    input  logic       sof_tick,
    output logic       clk_out,
    output logic       dma_arm,
    output logic       irq
);
    cfg_byte_t cfg_q;
    logic      div_q;
    out_mode_e mode;

    initial begin
        if (N_RST > N_MAX || N_MAX >= (1 << DIV_W))
            $error("refclk_div_top: divide parameters out of range");
    end

    cfg_store #(.N_MAX(N_MAX), .N_RST(N_RST)) u_cfg (
        .clk     (ref_clk),
        .por     (por),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cfg_q   (cfg_q)
    );

    div_core #(.N_RST(N_RST)) u_div (
        .clk      (ref_clk),
        .por      (por),
        .n_shadow (cfg_q.div_n),
        .div_q    (div_q),
        .mode     (mode)
    );

    out_mux u_mux (
        .ref_clk (ref_clk),
        .div_q   (div_q),
        .mode    (mode),
        .clk_out (clk_out)
    );

    irq_sel u_irq (
        .clk          (ref_clk),
        .por          (por),
        .bus_rst      (bus_rst),
        .sof_only     (cfg_q.sof_only),
        .evt_irq      (evt_irq),
        .alt_sof_mode (alt_sof_mode),
        .sof_tick     (sof_tick),
        .irq_q        (irq)
    );

    assign cfg_rdata = cfg_q;
    assign dma_arm   = cfg_q.dma_arm;

    p_bus_rst_keeps_cfg_r7: assert property (@(posedge ref_clk) disable iff (por)
        (bus_rst && !wr_en) |=> (cfg_rdata == $past(cfg_rdata)));

    p_arm_matches_byte_r3: assert property (@(posedge ref_clk) disable iff (por)
        dma_arm == cfg_rdata[6]);

endmodule

// File: tb/tb_refclk_div_top.sv
`timescale 1ns/1ps
module tb_refclk_div_top;

    logic       clk = 1'b0;
    logic       por = 1'b1, bus_rst = 1'b0, wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] cfg_rdata;
    logic       evt_irq = 1'b0, alt_sof_mode = 1'b0, sof_tick = 1'b0;
    logic       clk_out, dma_arm, irq;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    refclk_div_top dut (
        .ref_clk(clk), .por(por), .bus_rst(bus_rst), .wr_en(wr_en),
        .wr_data(wr_data), .cfg_rdata(cfg_rdata), .evt_irq(evt_irq),
        .alt_sof_mode(alt_sof_mode), .sof_tick(sof_tick),
        .clk_out(clk_out), .dma_arm(dma_arm), .irq(irq)
    );

    // {write value, expected read-back, expected high length, expected low length}
    localparam logic [23:0] VECS [0:8] = '{
        24'h0B_0B_66, 24'h05_05_33, 24'h04_04_32, 24'h01_01_11, 24'h02_02_21,
        24'hFF_CB_66, 24'h37_07_44, 24'h0F_0B_66, 24'h4A_4A_65
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic smp(output logic v);
        @(posedge clk);
        #1;
        v = clk_out;
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1;
        wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // locks onto a rising output, optionally writes in that cycle, then times one period
    task automatic measure(input bit do_wr, input logic [7:0] d,
                           output int hi, output int lo);
        logic p, v;
        int guard;
        smp(v);
        p = v;
        guard = 0;
        smp(v);
        while (!(p == 1'b0 && v == 1'b1) && guard < 64) begin
            p = v;
            smp(v);
            guard++;
        end
        if (do_wr) begin
            wr_en = 1'b1;
            wr_data = d;
        end
        hi = 1;
        lo = 0;
        smp(v);
        wr_en = 1'b0;
        while (v == 1'b1 && hi < 64) begin
            hi++;
            smp(v);
        end
        while (v == 1'b0 && lo < 64) begin
            lo++;
            smp(v);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int hi, lo, bad;
        logic v;

        // R2: state during and after power-on reset
        idle(3);
        chk("R2 reset byte", cfg_rdata, 8'h0B);
        chk("R2 reset arm", dma_arm, 0);
        chk("R2 reset irq", irq, 0);
        por = 1'b0;
        measure(1'b0, 8'h00, hi, lo);
        chk("R2 reset high", hi, 6);
        chk("R2 reset low", lo, 6);

        // R1 R3 R4: vector table
        for (int i = 0; i < 9; i++) begin
            wr(VECS[i][23:16]);
            chk("R3 R4 readback", cfg_rdata, VECS[i][15:8]);
            chk("R3 arm bit", dma_arm, VECS[i][14]);
            idle(30);
            measure(1'b0, 8'h00, hi, lo);
            chk("R1 high phase", hi, VECS[i][7:4]);
            chk("R1 low phase", lo, VECS[i][3:0]);
        end

        // R5: write mid-period, current period keeps old lengths
        wr(8'h0B);
        idle(30);
        measure(1'b1, 8'h03, hi, lo);
        chk("R5 old high kept", hi, 6);
        chk("R5 old low kept", lo, 6);
        chk("R5 readback new", cfg_rdata, 8'h03);
        measure(1'b0, 8'h00, hi, lo);
        chk("R5 new high", hi, 2);
        chk("R5 new low", lo, 2);

        // R6: bypass and back
        wr(8'h00);
        idle(30);
        bad = 0;
        for (int k = 0; k < 8; k++) begin
            @(posedge clk); #1;
            if (clk_out !== 1'b1) bad++;
            @(negedge clk); #1;
            if (clk_out !== 1'b0) bad++;
        end
        chk("R6 bypass follows reference", bad, 0);
        wr(8'h02);
        idle(30);
        measure(1'b0, 8'h00, hi, lo);
        chk("R6 leave bypass high", hi, 2);
        chk("R6 leave bypass low", lo, 1);

        // R7: bus reset keeps configuration and divider, drops irq
        wr(8'h44);
        idle(30);
        evt_irq = 1'b1;
        bus_rst = 1'b1;
        smp(v);
        chk("R7 irq dropped", irq, 0);
        smp(v);
        chk("R7 irq held low", irq, 0);
        chk("R7 byte kept", cfg_rdata, 8'h44);
        bus_rst = 1'b0;
        measure(1'b0, 8'h00, hi, lo);
        chk("R7 divider high", hi, 3);
        chk("R7 divider low", lo, 2);

        // R9: ordinary interrupt mode
        evt_irq = 1'b1; alt_sof_mode = 1'b0; sof_tick = 1'b0;
        smp(v);
        chk("R9 event irq", irq, 1);
        evt_irq = 1'b0; sof_tick = 1'b1;
        smp(v);
        chk("R9 sof without alt", irq, 0);
        alt_sof_mode = 1'b1;
        smp(v);
        chk("R9 sof with alt", irq, 1);
        sof_tick = 1'b0;
        smp(v);
        chk("R9 quiet", irq, 0);

        // R8: SOF-only mode
        wr(8'h8B);
        evt_irq = 1'b1; alt_sof_mode = 1'b1; sof_tick = 1'b0;
        smp(v);
        chk("R8 events ignored", irq, 0);
        alt_sof_mode = 1'b0; sof_tick = 1'b1;
        smp(v);
        chk("R8 sof drives irq", irq, 1);
        sof_tick = 1'b0; evt_irq = 1'b0;
        smp(v);
        chk("R8 sof gone", irq, 0);

        // R2: power-on reset restores the byte
        por = 1'b1;
        idle(2);
        por = 1'b0;
        chk("R2 por restores byte", cfg_rdata, 8'h0B);
        chk("R2 por clears arm", dma_arm, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule